// File: doc/BRIEF.md
# Mersenne Residue Reducer with Residue Equality Check

This block takes an unsigned data word and produces its residue modulo a Mersenne number M = 2^K - 1, where K is a parameter. The word is cut into K-bit slices, zero-padded at the top when the width is not a multiple of K. The slices are then summed in a balanced tree of K-bit adders with end-around carry. Every adder is a row of full-adder cells, with half adders only where one input is known to be zero. The carry out of the top bit is folded back into the least significant position. The result can be registered (one cycle of latency) or left combinational.

Because of the end-around carry, the residue zero has two codes: all zeros and all ones. A nonzero word whose value is a multiple of M always comes out as all ones. Only the zero word gives all zeros. A companion comparator takes two K-bit residues and reports equality modulo M, so it treats those two codes of zero as the same value. It is meant for checking shadow computations against residues produced by this reducer.

Top module: `mres_reducer_top`

## Requirements
- R1: After each rising clock edge with reset low, `res_out` interpreted as an unsigned number is congruent modulo M = 2^K - 1 to the value `din` held before that edge (one cycle of latency when OUT_REG = 1, the default).
- R2: A `din` of zero yields `res_out` equal to all zeros one cycle later.
- R3: A nonzero `din` that is a multiple of M yields `res_out` equal to all ones one cycle later. This is the redundant code for zero.
- R4: While `rst` is high at a rising edge, `res_out` becomes all zeros after that edge, whatever `din` holds.
- R5: `cmp_eq` is 1 whenever `cmp_a` and `cmp_b` hold the same code.
- R6: `cmp_eq` is 1 when one of `cmp_a` and `cmp_b` is all zeros and the other is all ones.
- R7: `cmp_eq` is 0 whenever `cmp_a` and `cmp_b` represent different values modulo M.
- R8: The parameter K may be any value from 2 to 8. When the data width is not a multiple of K (for example K = 5 with a 32-bit word), R1 to R3 still hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| din | input | DW (32) | Unsigned word to reduce |
| res_out | output | K | Residue of `din` modulo 2^K - 1; all ones is an alternative code for zero |
| cmp_a | input | K | First residue to compare |
| cmp_b | input | K | Second residue to compare |
| cmp_eq | output | 1 | 1 when `cmp_a` and `cmp_b` are equal modulo 2^K - 1 |

## Verification
The clocked residue properties assume that `din` holds known, stable values at every rising edge once reset is released. They compare the registered output against the previous cycle's word using the plain remainder operator. The comparator properties assume that `cmp_a` and `cmp_b` are known at each edge.

The stimulus changes `din` and the compare inputs only on falling edges and drives every input from the first cycle. It starts with reset high, so no property ever samples an undriven input. It covers a vector table, a seeded random sweep, and an exhaustive sweep of compare pairs for K = 2 and K = 5.

// File: rtl/mres_pkg.sv
package mres_pkg;

    // Result of one adder cell: sum bit and carry out.
    typedef struct packed {
        logic sum;
        logic cout;
    } add_bit_t;

    function automatic add_bit_t full_add(input logic a, input logic b, input logic ci);
        add_bit_t r;
        r.sum  = a ^ b ^ ci;
        r.cout = (a & b) | (ci & (a ^ b));
        return r;
    endfunction

    function automatic add_bit_t half_add(input logic a, input logic b);
        add_bit_t r;
        r.sum  = a ^ b;
        r.cout = a & b;
        return r;
    endfunction

    // Number of K-bit slices needed to cover a word of width w.
    function automatic int slice_count(input int w, input int k);
        return (w + k - 1) / k;
    endfunction

    // Smallest power of two that is >= n (n >= 1).
    function automatic int pow2_ceil(input int n);
        int p;
        p = 1;
        while (p < n) p = p * 2;
        return p;
    endfunction

endpackage

// File: rtl/mres_eac_adder.sv
// K-bit adder modulo 2^K-1: full-adder ripple row, then the carry out of the
// top bit re-enters at bit 0 through a half-adder increment row. Both inputs
// are at most 2^K-1, so the increment row can never carry out again.
module mres_eac_adder
    import mres_pkg::*;
#(
    parameter int K = 2
) (
    input  logic [K-1:0] a,
    input  logic [K-1:0] b,
    output logic [K-1:0] y
);
    add_bit_t [K-1:0] row;
    logic     [K:0]   c;
    logic     [K-1:0] inc;

    assign c[0] = 1'b0;

    for (genvar i = 0; i < K; i++) begin : g_row
        if (i == 0) begin : g_lsb
            assign row[i] = half_add(a[i], b[i]);
        end else begin : g_fa
            assign row[i] = full_add(a[i], b[i], c[i]);
        end
        assign c[i+1] = row[i].cout;
    end

    // Wraparound: the top carry becomes the increment at bit 0.
    assign inc[0] = c[K];
    for (genvar i = 0; i < K; i++) begin : g_wrap
        assign y[i] = row[i].sum ^ inc[i];
        if (i < K - 1) begin : g_ic
            assign inc[i+1] = row[i].sum & inc[i];
        end
    end
endmodule

// File: rtl/mres_tree.sv
// Balanced reduction tree of end-around-carry adders over zero-padded slices.
module mres_tree
    import mres_pkg::*;
#(
    parameter int DW = 32,
    parameter int K  = 2
) (
    input  logic [DW-1:0] word,
    output logic [K-1:0]  residue
);
    localparam int NSL   = slice_count(DW, K);
    localparam int PW    = NSL * K;
    localparam int LEAVES = pow2_ceil(NSL);
    localparam int NODES = 2 * LEAVES - 1;

    logic [PW-1:0]            padded;
    logic [NODES-1:0][K-1:0]  node;

    assign padded = PW'(word);

    // Leaves: real slices first, constant zero beyond the last slice.
    for (genvar i = 0; i < LEAVES; i++) begin : g_leaf
        if (i < NSL) begin : g_slice
            assign node[LEAVES-1+i] = padded[i*K +: K];
        end else begin : g_zero
            assign node[LEAVES-1+i] = '0;
        end
    end

    // Internal node j combines children 2j+1 and 2j+2.
    for (genvar j = 0; j < LEAVES - 1; j++) begin : g_node
        mres_eac_adder #(.K(K)) u_add (
            .a (node[2*j+1]),
            .b (node[2*j+2]),
            .y (node[j])
        );
    end

    assign residue = node[0];
endmodule

// File: rtl/mres_equal.sv
// Equality modulo 2^K-1 on residues that may use either code for zero.
module mres_equal #(
    parameter int K = 2
) (
    input  logic [K-1:0] a,
    input  logic [K-1:0] b,
    output logic         eq
);
    logic a_zero, a_ones, b_zero, b_ones, same;

    assign a_zero = ~|a;
    assign a_ones = &a;
    assign b_zero = ~|b;
    assign b_ones = &b;
    assign same   = ~|(a ^ b);

    assign eq = same | (a_zero & b_ones) | (a_ones & b_zero);
endmodule

// File: rtl/mres_reducer_top.sv
module mres_reducer_top
    import mres_pkg::*;
#(
    parameter int DW      = 32,
    parameter int K       = 2,
    parameter bit OUT_REG = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] din,
    output logic [K-1:0]  res_out,
    input  logic [K-1:0]  cmp_a,
    input  logic [K-1:0]  cmp_b,
    output logic          cmp_eq
);
    localparam logic [DW-1:0] MODV = DW'((1 << K) - 1);

    logic [K-1:0] tree_res;

    mres_tree #(.DW(DW), .K(K)) u_tree (
        .word    (din),
        .residue (tree_res)
    );

    if (OUT_REG) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) res_out <= '0;
            else     res_out <= tree_res;
        end

        // R1: registered residue is congruent to the previous word
        a_r1_congruent: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> ((DW'(res_out) % MODV) == ($past(din) % MODV)));

        // R2: zero word gives the all-zeros code
        a_r2_zero_code: assert property (@(posedge clk) disable iff (rst)
            (din == '0) |=> (res_out == '0));

        // R3: nonzero multiple of M gives the all-ones code
        a_r3_ones_code: assert property (@(posedge clk) disable iff (rst)
            ((din != '0) && ((din % MODV) == '0)) |=> (&res_out));
    end else begin : g_comb
        assign res_out = tree_res;
    end

    mres_equal #(.K(K)) u_eq (
        .a  (cmp_a),
        .b  (cmp_b),
        .eq (cmp_eq)
    );

    // R5/R6: residues equal modulo M must compare equal
    a_r6_eq_mod: assert property (@(posedge clk) disable iff (rst)
        ((DW'(cmp_a) % MODV) == (DW'(cmp_b) % MODV)) |-> cmp_eq);

    // R7: residues differing modulo M must compare unequal
    a_r7_ne_mod: assert property (@(posedge clk) disable iff (rst)
        ((DW'(cmp_a) % MODV) != (DW'(cmp_b) % MODV)) |-> !cmp_eq);
endmodule

// File: tb/tb_mres_reducer_top.sv
`timescale 1ns/1ps
module tb_mres_reducer_top;
    localparam int DW = 32;
    localparam int KA = 2;
    localparam int KB = 5;
    localparam logic [31:0] MA = 32'd3;
    localparam logic [31:0] MB = 32'd31;
    localparam int NV = 16;

    localparam logic [31:0] VEC [NV] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0003,
        32'h0000_0002, 32'h8000_0000, 32'h7FFF_FFFF, 32'h0000_001F,
        32'h0000_003E, 32'hAAAA_AAAA, 32'h5555_5555, 32'hDEAD_BEEF,
        32'h0000_03E1, 32'hF000_000F, 32'h1234_5678, 32'hC000_0000
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [DW-1:0] din = '0;
    logic [KA-1:0] res_a, ca_a = '0, cb_a = '0;
    logic [KB-1:0] res_b, ca_b = '0, cb_b = '0;
    logic eq_a, eq_b;
    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    mres_reducer_top #(.DW(DW), .K(KA)) dut (
        .clk(clk), .rst(rst), .din(din), .res_out(res_a),
        .cmp_a(ca_a), .cmp_b(cb_a), .cmp_eq(eq_a));

    mres_reducer_top #(.DW(DW), .K(KB)) dut_k5 (
        .clk(clk), .rst(rst), .din(din), .res_out(res_b),
        .cmp_a(ca_b), .cmp_b(cb_b), .cmp_eq(eq_b));

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Check one residue output against the word it came from.
    task automatic check_res(input string tag, input logic [31:0] w,
                             input logic [31:0] r, input logic [31:0] m);
        logic [31:0] ones;
        ones = m;  // M = 2^K-1 is also the all-ones code
        if (w == 0)
            check({tag, " R2 zero word"}, r, 32'd0);
        else if (w % m == 0)
            check({tag, " R3 multiple of M"}, r, ones);
        else
            check({tag, " R1 congruence"}, r % m, w % m);
    endtask

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        din = w;
        @(negedge clk);
        check_res("K2", w, 32'(res_a), MA);
        check_res("K5 R8", w, 32'(res_b), MB);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R4: reset clears output even with a nonzero word present
        din = 32'hDEAD_BEEF;
        repeat (3) @(negedge clk);
        check("R4 reset K2", 32'(res_a), 32'd0);
        check("R4 reset K5", 32'(res_b), 32'd0);
        rst = 1'b0;

        // Vector table
        for (int i = 0; i < NV; i++) apply(VEC[i]);

        // Seeded random words, plus multiples of each modulus
        for (int i = 0; i < 200; i++) apply($urandom());
        for (int i = 1; i < 40; i++) apply(32'(i) * 32'd3 * 32'd31 * 32'd4111);

        // Reset in mid-stream: R4
        @(negedge clk);
        din = 32'h0000_0005;
        rst = 1'b1;
        @(negedge clk);
        check("R4 mid-run reset K2", 32'(res_a), 32'd0);
        check("R4 mid-run reset K5", 32'(res_b), 32'd0);
        rst = 1'b0;
        apply(32'h0000_0005);

        // Comparator sweeps, K=2 and K=5: R5 R6 R7
        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 4; b++) begin
                @(negedge clk);
                ca_a = KA'(a);
                cb_a = KA'(b);
                #1;
                if (a == b) check("R5 same code K2", 32'(eq_a), 32'd1);
                else if ((a % 3) == (b % 3)) check("R6 zero codes K2", 32'(eq_a), 32'd1);
                else check("R7 different values K2", 32'(eq_a), 32'd0);
            end
        end
        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                @(negedge clk);
                ca_b = KB'(a);
                cb_b = KB'(b);
                #1;
                if (a == b) check("R5 same code K5", 32'(eq_b), 32'd1);
                else if ((a % 31) == (b % 31)) check("R6 zero codes K5", 32'(eq_b), 32'd1);
                else check("R7 different values K5", 32'(eq_b), 32'd0);
            end
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule